// File: doc/BRIEF.md
# Transceiver Mode and Wake-Up Controller

This block is the digital control core of a two-wire differential bus transceiver. It takes a standby select, a sampled bus-state bit (1 = dominant), the transmit data line, two supply-good flags (main and I/O) and an over-temperature flag. From these it drives four outputs: the bus driver's dominant request, the common-mode reference enable, the receiver path select (high-speed or low-power) and the receive data line.

All timing is counted in cycles of one fixed clock. In normal mode the driver follows transmit data and receive data follows the bus directly. In standby only the low-power receive path runs. A dominant level must then last for a programmable number of samples before receive data goes low. Leaving standby passes through a programmable settling interval before the driver may act. Supply faults and the thermal flag each gate only their own outputs.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: A high `stby_i` sampled on a rising edge puts the block in standby after that edge. In standby `drv_dom_o`, `split_en_o` and `rx_hs_o` are 0.
- R2: In normal mode with both supplies good and no over-temperature: `drv_dom_o` equals the inverse of `txd_i`, `rxd_o` equals the inverse of `bus_dom_i`, `rx_hs_o` is 1 and `split_en_o` is 1.
- R3: Outside normal mode, `rxd_o` goes to 0 only after `WAKE_CYC` consecutive rising edges have sampled `bus_dom_i` = 1. It returns to 1 after the first edge that samples `bus_dom_i` = 0.
- R4: Outside normal mode, a dominant run of `WAKE_CYC`-1 samples or fewer leaves `rxd_o` at 1 throughout.
- R5: From standby, normal mode begins after the `SETTLE_CYC`-th consecutive edge that samples `stby_i` low. Until then `drv_dom_o`, `split_en_o` and `rx_hs_o` stay 0 and `rxd_o` keeps its standby behaviour. A high `stby_i` during this interval returns the block to standby.
- R6: `drv_dom_o` stays 0 until an edge has sampled `vdd_ok_i` and `vio_ok_i` both 1. After that, losing `vio_ok_i` alone does not disable the driver. Any loss of `vdd_ok_i` disables it at once, and it stays disabled until both flags have again been sampled 1 together.
- R7: In normal mode with `vdd_ok_i` = 0, `rxd_o` is 1 and `split_en_o` is 0.
- R8: `otemp_i` = 1 forces `drv_dom_o` to 0 and changes no other output.
- R9: After reset the block is in standby, with `rxd_o` = 1 and the other three outputs 0.
- R10: When the block enters standby from normal mode, the wake filter starts counting from zero. The edge that enters standby does not count as a dominant sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | 1 = standby requested, 0 = normal requested |
| txd_i | input | 1 | Transmit data, 0 = drive dominant |
| bus_dom_i | input | 1 | Sampled bus state, 1 = dominant |
| vdd_ok_i | input | 1 | Main supply above its threshold |
| vio_ok_i | input | 1 | I/O supply above its threshold |
| otemp_i | input | 1 | Junction over-temperature |
| drv_dom_o | output | 1 | Driver pulls the bus dominant |
| split_en_o | output | 1 | Common-mode reference output enabled |
| rx_hs_o | output | 1 | 1 = high-speed receiver, 0 = low-power receiver |
| rxd_o | output | 1 | Receive data, 0 = dominant |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and stable across each rising edge, with `bus_dom_i` already resolved to one bit. The bench changes every input only on falling edges, so every sample is clean. It draws random run lengths for the dominant level around the filter length, rare standby and supply toggles, and a random data stream. This reaches wake-ups, aborted settles and supply loss in every mode, while directed sequences hit the exact filter and settling boundaries.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_STBY   = 2'd0,
    MODE_SETTLE = 2'd1,
    MODE_NORM   = 2'd2
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_mode_seq.sv
module xcvr_mode_seq
  import xcvr_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 2500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_i,
  output xcvr_mode_e mode_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SC_LAST = SW'(SETTLE_CYC - 1);

  xcvr_mode_e mode_q;
  logic [SW-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STBY;
      sc_q   <= '0;
    end else if (stby_i) begin
      mode_q <= MODE_STBY;
      sc_q   <= '0;
    end else begin
      unique case (mode_q)
        MODE_STBY: begin
          // first low sample counts as one
          mode_q <= (SETTLE_CYC <= 1) ? MODE_NORM : MODE_SETTLE;
          sc_q   <= SW'(1);
        end
        MODE_SETTLE: begin
          if (sc_q == SC_LAST) mode_q <= MODE_NORM;
          else                 sc_q   <= sc_q + SW'(1);
        end
        default: mode_q <= MODE_NORM;
      endcase
    end
  end

  assign mode_o = mode_q;

  a_r1_stby_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (mode_q == MODE_STBY));

  a_r5_settle_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SETTLE) |-> (sc_q < SW'(SETTLE_CYC)));

  generate
    if (SETTLE_CYC > 1) begin : g_no_skip
      a_r5_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_STBY) |=> (mode_q != MODE_NORM));
    end
  endgenerate
endmodule

// File: rtl/xcvr_wake_filter.sv
module xcvr_wake_filter #(
  parameter int unsigned WAKE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dom_i,
  output logic wake_o
);
  localparam int unsigned WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WC_LAST = WW'(WAKE_CYC - 1);

  logic [WW-1:0] cnt_q;
  logic          wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else if (!en_i || !dom_i) begin
      cnt_q  <= '0;
      wake_q <= 1'b0;
    end else if (!wake_q) begin
      if (cnt_q == WC_LAST) wake_q <= 1'b1;
      else                  cnt_q  <= cnt_q + WW'(1);
    end
  end

  assign wake_o = wake_q;

  a_r3_wake_needs_dom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> $past(dom_i && en_i));

  a_r3_recessive_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dom_i |=> !wake_q);

  a_r10_norm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wake_q);
endmodule

// File: rtl/xcvr_supply_gate.sv
module xcvr_supply_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vdd_ok_i,
  input  logic vio_ok_i,
  output logic drv_ok_o
);
  logic pwr_q;

  // armed once both supplies seen good; only main supply loss disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pwr_q <= 1'b0;
    else if (!vdd_ok_i)           pwr_q <= 1'b0;
    else if (vio_ok_i)            pwr_q <= 1'b1;
  end

  assign drv_ok_o = vdd_ok_i & (pwr_q | vio_ok_i);

  a_r6_vdd_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vdd_ok_i |=> !pwr_q);

  a_r6_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_q) |-> $past(vdd_ok_i && vio_ok_i));
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_pkg::*;
#(
  parameter int unsigned WAKE_CYC   = 100,
  parameter int unsigned SETTLE_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic txd_i,
  input  logic bus_dom_i,
  input  logic vdd_ok_i,
  input  logic vio_ok_i,
  input  logic otemp_i,
  output logic drv_dom_o,
  output logic split_en_o,
  output logic rx_hs_o,
  output logic rxd_o
);
  xcvr_mode_e mode;
  logic       is_norm;
  logic       wake;
  logic       drv_ok;

  xcvr_mode_seq #(.SETTLE_CYC(SETTLE_CYC)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stby_i (stby_i),
    .mode_o (mode)
  );

  assign is_norm = (mode == MODE_NORM);

  xcvr_wake_filter #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!is_norm),
    .dom_i  (bus_dom_i),
    .wake_o (wake)
  );

  xcvr_supply_gate i_supply (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vdd_ok_i (vdd_ok_i),
    .vio_ok_i (vio_ok_i),
    .drv_ok_o (drv_ok)
  );

  assign drv_dom_o  = is_norm & drv_ok & ~otemp_i & ~txd_i;
  assign split_en_o = is_norm & vdd_ok_i;
  assign rx_hs_o    = is_norm;
  assign rxd_o      = is_norm ? (~vdd_ok_i | ~bus_dom_i) : ~wake;

  a_r5_drv_only_norm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_dom_o) |-> (mode == MODE_NORM));
endmodule

// File: tb/test_xcvr_mode_ctrl.sv
module test_xcvr_mode_ctrl;
  localparam int W = 6;
  localparam int S = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b1, txd = 1'b1, dom = 1'b0, vdd = 1'b0, vio = 1'b0, ot = 1'b0;
  logic drv_dom, split_en, rx_hs, rxd;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xcvr_mode_ctrl #(.WAKE_CYC(W), .SETTLE_CYC(S)) i_xcvr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby), .txd_i(txd), .bus_dom_i(dom),
    .vdd_ok_i(vdd), .vio_ok_i(vio), .otemp_i(ot),
    .drv_dom_o(drv_dom), .split_en_o(split_en), .rx_hs_o(rx_hs), .rxd_o(rxd)
  );

  // reference model: 0 standby, 1 settling, 2 normal
  int m_mode, m_sc, m_wc;
  bit m_wake, m_pwr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sc = 0; m_wc = 0; m_wake = 0; m_pwr = 0;
    end else begin
      if (!vdd) m_pwr = 0; else if (vio) m_pwr = 1;
      if (m_mode == 2 || !dom) begin m_wc = 0; m_wake = 0; end
      else if (!m_wake) begin
        m_wc = m_wc + 1;
        if (m_wc >= W) m_wake = 1;
      end
      if (stby) begin m_mode = 0; m_sc = 0; end
      else if (m_mode == 0) begin m_sc = 1; m_mode = (S <= 1) ? 2 : 1; end
      else if (m_mode == 1) begin
        if (m_sc == S - 1) m_mode = 2; else m_sc = m_sc + 1;
      end
    end
  end

  function automatic bit e_drv();
    return (m_mode == 2) && vdd && (m_pwr || vio) && !ot && !txd;
  endfunction
  function automatic bit e_rxd();
    if (m_mode == 2) return !vdd || !dom;
    return !m_wake;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string t_drv, t_rxd;
    if (m_mode != 2) t_drv = "R5";
    else if (!(vdd && (m_pwr || vio))) t_drv = "R6";
    else if (ot) t_drv = "R8";
    else t_drv = "R2";
    t_rxd = (m_mode != 2) ? "R3" : (vdd ? "R2" : "R7");
    chk(t_drv, "drv_dom", drv_dom, e_drv());
    chk(t_rxd, "rxd", rxd, e_rxd());
    chk((m_mode == 2) ? "R2" : "R1", "rx_hs", rx_hs, m_mode == 2);
    chk(vdd ? "R1" : "R7", "split_en", split_en, (m_mode == 2) && vdd);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "drv_dom", drv_dom, 1'b0);
    chk("R9", "split_en", split_en, 1'b0);
    chk("R9", "rx_hs", rx_hs, 1'b0);
    chk("R9", "rxd", rxd, 1'b1);
    rst_n = 1'b1;

    // R6 power-up gating
    vdd = 1; vio = 0; stby = 0; txd = 0;
    repeat (S) tick();
    chk("R5", "rx_hs", rx_hs, 1'b1);
    chk("R6", "drv_dom no vio yet", drv_dom, 1'b0);
    vio = 1; tick();
    chk("R6", "drv_dom armed", drv_dom, 1'b1);
    vio = 0; tick();
    chk("R6", "drv_dom vio loss", drv_dom, 1'b1);
    vdd = 0; dom = 1; tick();
    chk("R6", "drv_dom vdd loss", drv_dom, 1'b0);
    chk("R7", "rxd under voltage", rxd, 1'b1);
    vdd = 1; tick();
    chk("R6", "drv_dom rearm needs both", drv_dom, 1'b0);
    vio = 1; tick();
    chk("R6", "drv_dom rearmed", drv_dom, 1'b1);

    // R8 thermal
    ot = 1; tick();
    chk("R8", "drv_dom hot", drv_dom, 1'b0);
    chk("R8", "rx_hs hot", rx_hs, 1'b1);
    chk("R8", "rxd hot", rxd, 1'b0);
    ot = 0;

    // R4 / R3 filter boundary
    stby = 1; txd = 1; dom = 0; tick();
    chk("R1", "rx_hs standby", rx_hs, 1'b0);
    dom = 1;
    for (int i = 0; i < W - 1; i++) begin
      tick();
      chk("R4", "rxd short pulse", rxd, 1'b1);
    end
    dom = 0; tick();
    chk("R4", "rxd after short pulse", rxd, 1'b1);
    dom = 1;
    for (int i = 0; i < W - 1; i++) tick();
    chk("R3", "rxd one short of filter", rxd, 1'b1);
    tick();
    chk("R3", "rxd at filter length", rxd, 1'b0);
    dom = 0; tick();
    chk("R3", "rxd released", rxd, 1'b1);

    // R5 settle timing, standby rx behaviour kept
    stby = 0; dom = 1;
    for (int i = 0; i < S - 1; i++) tick();
    chk("R5", "rx_hs before settle end", rx_hs, 1'b0);
    chk("R5", "rxd filtered in settle", rxd, 1'b0);
    tick();
    chk("R5", "rx_hs at settle end", rx_hs, 1'b1);
    dom = 0;
    stby = 1; tick();
    stby = 0; repeat (3) tick();
    stby = 1; tick();
    chk("R5", "rx_hs aborted settle", rx_hs, 1'b0);

    // R10 filter restarts when leaving normal
    stby = 0; dom = 1;
    repeat (S) tick();
    chk("R2", "rxd normal dominant", rxd, 1'b0);
    stby = 1;
    for (int i = 0; i < W; i++) tick();
    chk("R10", "rxd before restart count", rxd, 1'b1);
    tick();
    chk("R10", "rxd after restart count", rxd, 1'b0);

    // random phase
    for (int n = 0; n < 30000; n++) begin
      if ($urandom % 300 == 0) stby = ~stby;
      if ($urandom % W == 0) dom = ~dom;
      txd = 1'($urandom);
      if (vdd) begin if ($urandom % 500 == 0) vdd = 0; end
      else if ($urandom % 20 == 0) vdd = 1;
      if (vio) begin if ($urandom % 400 == 0) vio = 0; end
      else if ($urandom % 30 == 0) vio = 1;
      if ($urandom % 400 == 0) ot = ~ot;
      tick();
    end
    finish_run();
  end
endmodule